// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

An 8-bit down-counting timer with a clock prescaler, run through a small synchronous register bus. The bus has an address, write data, a write strobe and combinational read data. One control/status register holds the run bit, the reload policy and the prescale choice. It also holds two interrupt masks, the pin source select and a sticky time-out flag. A second register holds the initial count.

On every terminal count the timer sets the time-out flag, toggles its output and can raise a one-cycle interrupt request. In periodic mode it then reloads and keeps running. In one-shot mode it stops and drops its run bit. One output pin carries either a general-purpose port bit or the timer output, as the register selects. The capture mask is only stored and read back.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, the control register (address 0) and the reload register (address 1) read 0x00, `irq_o` is 0 and `pin_o` follows `port_bit_i`.
- R2: The control register fields read back as written: bit 7 run, bit 6 one-shot (1) / periodic (0), bits 4:3 prescale code, bit 2 capture mask, bit 1 time-out interrupt mask, bit 0 pin select. The reload register at address 1 reads back its full 8 bits. Other addresses read 0x00.
- R3: A write that sets bit 7 while it reads 0 loads the counter from the reload register. While running, each prescale tick decrements the counter. Terminal count is the step from 1 to 0. A reload of 0 gives 256 ticks.
- R4: In periodic mode, terminal count reloads the counter and counting continues, so the period is reload-value ticks.
- R5: In one-shot mode, terminal count leaves the counter at 0 and clears bit 7 in the same edge. This hardware clear wins over a simultaneous write of 1 to bit 7.
- R6: A free-running 3-bit phase counter starts at 0 after reset and steps every clock. With prescale code k (divide by 2^k), a tick occurs in the cycles where the low k bits of the phase are all ones.
- R7: Bit 5 is set at terminal count. It is cleared only by writing 1 to it. Writing 0 to it leaves it unchanged.
- R8: If terminal count and a write of 1 to bit 5 happen in the same cycle, bit 5 ends up 1.
- R9: `irq_o` is high for exactly the cycle after each terminal-count edge, and only when bit 1 was 1 at that edge.
- R10: The timer output starts at 0 and toggles at each terminal count. `pin_o` carries it when bit 0 is 1, and carries `port_bit_i` when bit 0 is 0.
- R11: The capture mask bit has no effect on counting, `irq_o` or `pin_o`. It is only stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Time-out interrupt request pulse |
| port_bit_i | input | 1 | General-purpose port output bit |
| pin_o | output | 1 | Shared pin: port bit or timer output |

## Verification
Directed sequences run periodic and one-shot counts at divide-by-1 with short reloads. These pin down the exact edge of terminal count and show whether the timer reloads or stops. A divide-by-8 run counts interrupts over a fixed window, which tells the prescale ratio apart from an off-by-one in the tick phase. Targeted writes place a flag clear on the same edge as a terminal count, and write 0 to the flag, to separate set-wins and sticky behaviour from a plain clear. Long random sequences of register writes, with random port bits, then follow a cycle model of flag, interrupt and pin behaviour across every mode and prescale mix.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 2;
  localparam int PH_W        = 3;
  localparam int CTRL_ADDR   = 0;
  localparam int RELOAD_ADDR = 1;
  localparam int RUN_BIT     = 7;
  localparam int ONE_BIT     = 6;
  localparam int FLAG_BIT    = 5;
  localparam int DIV_HI      = 4;
  localparam int DIV_LO      = 3;
  localparam int CAP_BIT     = 2;
  localparam int TMO_BIT     = 1;
  localparam int SEL_BIT     = 0;

  typedef struct packed {
    logic       run;
    logic       one_shot;
    logic       flag;
    logic [1:0] div;
    logic       cap_mask;
    logic       tmo_mask;
    logic       pin_sel;
  } ctrl_t;
endpackage

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
  parameter int PH_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_i,
  output logic       tick_o
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < PH_W; i++) mask[i] = (i < int'(div_i));
  end

  assign tick_o = ((phase_q & mask) == mask);

  // R6
  div1_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == 2'd0) |-> tick_o);
endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         load_i,
  input  logic         tick_i,
  input  logic         one_shot_i,
  input  logic [W-1:0] reload_i,
  output logic         term_o,
  output logic         tout_o
);
  logic [W-1:0] cnt_q;
  logic         tout_q;
  logic         step;

  assign step   = run_i & tick_i & ~load_i;
  assign term_o = step & (cnt_q == W'(1));
  assign tout_o = tout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tout_q <= 1'b0;
    end else begin
      if (load_i)      cnt_q <= reload_i;
      else if (term_o) cnt_q <= one_shot_i ? '0 : reload_i;
      else if (step)   cnt_q <= cnt_q - 1'b1;
      if (term_o) tout_q <= ~tout_q;
    end
  end

  // R3
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(reload_i)));
  // R10
  tout_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tout_q != $past(tout_q)) |-> $past(term_o));
  // R3
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              term_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              run_o,
  output logic              one_shot_o,
  output logic [1:0]        div_o,
  output logic              pin_sel_o,
  output logic              load_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic              irq_q;
  logic              wr_ctrl, wr_reload;

  assign wr_ctrl   = we_i && (addr_i == ADDR_W'(CTRL_ADDR));
  assign wr_reload = we_i && (addr_i == ADDR_W'(RELOAD_ADDR));
  assign load_o    = wr_ctrl && wdata_i[RUN_BIT] && !ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run      <= wdata_i[RUN_BIT];
        ctrl_q.one_shot <= wdata_i[ONE_BIT];
        ctrl_q.div      <= wdata_i[DIV_HI:DIV_LO];
        ctrl_q.cap_mask <= wdata_i[CAP_BIT];
        ctrl_q.tmo_mask <= wdata_i[TMO_BIT];
        ctrl_q.pin_sel  <= wdata_i[SEL_BIT];
      end
      // one-shot stop beats a same-cycle run write
      if (term_i && ctrl_q.one_shot) ctrl_q.run <= 1'b0;
      // set beats write-one-to-clear
      if (term_i)                            ctrl_q.flag <= 1'b1;
      else if (wr_ctrl && wdata_i[FLAG_BIT]) ctrl_q.flag <= 1'b0;
      if (wr_reload) reload_q <= wdata_i;
      irq_q <= term_i && ctrl_q.tmo_mask;
    end
  end

  always_comb begin
    if (addr_i == ADDR_W'(CTRL_ADDR))        rdata_o = ctrl_q;
    else if (addr_i == ADDR_W'(RELOAD_ADDR)) rdata_o = reload_q;
    else                                     rdata_o = '0;
  end

  assign reload_o   = reload_q;
  assign run_o      = ctrl_q.run;
  assign one_shot_o = ctrl_q.one_shot;
  assign div_o      = ctrl_q.div;
  assign pin_sel_o  = ctrl_q.pin_sel;
  assign irq_o      = irq_q;

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.flag && !(wr_ctrl && wdata_i[FLAG_BIT])) |=> ctrl_q.flag);
  // R8
  flag_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i |=> ctrl_q.flag);
  // R9
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ctrl_q.flag);
  // R5
  one_shot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && ctrl_q.one_shot) |=> !ctrl_q.run);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptimer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              port_bit_i,
  output logic              pin_o
);
  logic [DATA_W-1:0] reload;
  logic              run, one_shot, pin_sel, load, tick, term, tout;
  logic [1:0]        div;

  ptimer_regs i_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .term_i    (term),
    .rdata_o,
    .reload_o  (reload),
    .run_o     (run),
    .one_shot_o(one_shot),
    .div_o     (div),
    .pin_sel_o (pin_sel),
    .load_o    (load),
    .irq_o
  );

  ptimer_prescale #(.PH_W(PH_W)) i_prescale (
    .clk_i, .rst_ni,
    .div_i (div),
    .tick_o(tick)
  );

  ptimer_count #(.W(DATA_W)) i_count (
    .clk_i, .rst_ni,
    .run_i     (run),
    .load_i    (load),
    .tick_i    (tick),
    .one_shot_i(one_shot),
    .reload_i  (reload),
    .term_o    (term),
    .tout_o    (tout)
  );

  assign pin_o = pin_sel ? tout : port_bit_i;

  // R10
  pin_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_sel |-> (pin_o == port_bit_i));
endmodule

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic       port_bit_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o, pin_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic m_run, m_one, m_flag, m_cap, m_tmo, m_sel, m_tout, m_irq;
  logic [1:0] m_div;
  logic [7:0] m_reload, m_cnt;
  logic [2:0] m_ph;

  prescaled_timer i_prescaled_timer (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic ptick(logic [2:0] ph, logic [1:0] dv);
    case (dv)
      2'd0: return 1'b1;
      2'd1: return ph[0];
      2'd2: return &ph[1:0];
      default: return &ph;
    endcase
  endfunction

  function automatic logic [7:0] mread(logic [1:0] a);
    if (a == 2'd0) return {m_run, m_one, m_flag, m_div, m_cap, m_tmo, m_sel};
    if (a == 2'd1) return m_reload;
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mreset();
    {m_run, m_one, m_flag, m_cap, m_tmo, m_sel, m_tout, m_irq} = '0;
    m_div = '0; m_reload = '0; m_cnt = '0; m_ph = '0;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic we, logic [1:0] a, logic [7:0] d, logic port);
    logic tk, wc, ld, tm, n_run;
    we_i = we; addr_i = a; wdata_i = d; port_bit_i = port;
    tk = ptick(m_ph, m_div);
    wc = we && (a == 2'd0);
    ld = wc && d[7] && !m_run;
    tm = m_run && !ld && tk && (m_cnt == 8'd1);
    n_run = wc ? d[7] : m_run;
    if (tm && m_one) n_run = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    if (ld) m_cnt = m_reload;
    else if (tm) m_cnt = m_one ? 8'd0 : m_reload;
    else if (m_run && tk) m_cnt = m_cnt - 8'd1;
    if (tm) m_tout = ~m_tout;
    m_irq = tm && m_tmo;
    if (tm) m_flag = 1'b1;
    else if (wc && d[5]) m_flag = 1'b0;
    if (wc) begin
      m_one = d[6]; m_div = d[4:3]; m_cap = d[2]; m_tmo = d[1]; m_sel = d[0];
    end
    m_run = n_run;
    if (we && a == 2'd1) m_reload = d;
    m_ph = m_ph + 3'd1;
  endtask

  task automatic idle(logic port);
    step(1'b0, 2'd0, 8'h00, port);
  endtask

  task automatic cmp_all(string tag);
    check({tag, " R9 irq"}, irq_o, m_irq);
    check({tag, " R10 pin"}, pin_o, m_sel ? m_tout : port_bit_i);
    check({tag, " R2 rdata"}, rdata_o, mread(addr_i));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int irqs;
    logic [31:0] seed;
    mreset();
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    step(1'b0, 2'd0, 8'h00, 1'b1);
    check("R1 ctrl after reset", rdata_o, 8'h00);
    check("R1 irq after reset", irq_o, 1'b0);
    check("R1 pin follows port", pin_o, 1'b1);
    step(1'b0, 2'd1, 8'h00, 1'b0);
    check("R1 reload after reset", rdata_o, 8'h00);
    check("R1 pin follows port low", pin_o, 1'b0);

    // R2 / R11 field readback
    step(1'b1, 2'd0, 8'h5E, 1'b0);
    check("R2 ctrl readback", rdata_o, 8'h5E);
    check("R11 capture mask stored", rdata_o[2], 1'b1);
    step(1'b1, 2'd1, 8'hA5, 1'b0);
    check("R2 reload readback", rdata_o, 8'hA5);
    step(1'b0, 2'd2, 8'h00, 1'b0);
    check("R2 unmapped reads zero", rdata_o, 8'h00);

    // R3 / R4 periodic, reload 3, divide by 1
    step(1'b1, 2'd1, 8'd3, 1'b0);
    step(1'b1, 2'd0, 8'h82, 1'b0);
    idle(1'b0); check("R3 no irq after 1 tick", irq_o, 1'b0);
    idle(1'b0); check("R3 no irq after 2 ticks", irq_o, 1'b0);
    idle(1'b0); check("R3 irq at terminal count", irq_o, 1'b1);
    check("R7 flag set at terminal", rdata_o[5], 1'b1);
    idle(1'b0); check("R9 irq one cycle", irq_o, 1'b0);
    idle(1'b0); check("R4 no irq mid period", irq_o, 1'b0);
    idle(1'b0); check("R4 irq after reload period", irq_o, 1'b1);

    // R7 sticky: write 0 to flag leaves it, write 1 clears
    step(1'b1, 2'd0, 8'h02, 1'b0);
    check("R7 write 0 keeps flag", rdata_o[5], 1'b1);
    step(1'b1, 2'd0, 8'h22, 1'b0);
    check("R7 write 1 clears flag", rdata_o[5], 1'b0);

    // R5 one-shot, reload 2
    step(1'b1, 2'd1, 8'd2, 1'b0);
    step(1'b1, 2'd0, 8'hC2, 1'b0);
    idle(1'b0); check("R5 no irq early", irq_o, 1'b0);
    idle(1'b0); check("R5 irq at terminal", irq_o, 1'b1);
    check("R5 run cleared, flag set", rdata_o, 8'h62);
    for (int i = 0; i < 6; i++) idle(1'b0);
    check("R5 stays stopped", irq_o, 1'b0);

    // R8 set wins over same-cycle clear (reload 1, divide 1: terminal every tick)
    step(1'b1, 2'd0, 8'h22, 1'b0);
    step(1'b1, 2'd1, 8'd1, 1'b0);
    step(1'b1, 2'd0, 8'h82, 1'b0);
    step(1'b1, 2'd0, 8'h22, 1'b0);
    idle(1'b0);
    check("R8 set beats clear", rdata_o, 8'h22);

    // R6 divide by 8: four terminals in 32 cycles
    step(1'b1, 2'd0, 8'h9A, 1'b0);
    irqs = 0;
    for (int i = 0; i < 32; i++) begin idle(1'b0); irqs += irq_o; end
    check("R6 divide-by-8 irq count", irqs, 4);

    // R9 mask off, R10 pin carries timer output
    step(1'b1, 2'd0, 8'h20, 1'b0);
    step(1'b1, 2'd0, 8'h81, 1'b0);
    irqs = 0;
    for (int i = 0; i < 8; i++) begin
      idle(1'b1); irqs += irq_o;
      check("R10 pin is timer output", pin_o, m_tout);
    end
    check("R9 no irq when masked", irqs, 0);
    check("R7 flag set without irq", rdata_o[5], 1'b1);
    step(1'b1, 2'd0, 8'h84, 1'b1);
    check("R10 pin back to port", pin_o, 1'b1);
    check("R11 cap mask no irq", irq_o, 1'b0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      r = 4'($urandom());
      if (r < 4'd3)      step(1'b1, 2'd0, 8'($urandom()), 1'($urandom()));
      else if (r == 4'd3) step(1'b1, 2'd1, 8'($urandom_range(6)), 1'($urandom()));
      else               step(1'b0, 2'($urandom()), 8'h00, 1'($urandom()));
      cmp_all("rand");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule